// File: doc/BRIEF.md
# Sleep and Transparent Bypass Control

This block governs the low-power sleep state of a stereo audio codec. When the sleep pin is high, it turns off the enables of every internal clock. It then decides, for each of three output pins, whether that pin passes an outside signal straight through or is released to high impedance. The three pins are the master clock output, the serial data output and an auxiliary word-select output. While the chip is awake, all three pins carry the codec's own internal signals.

Two settings bits control the bypass: a transparent-mode bit and a word-select-routing bit. Both are sampled once, when sleep is entered. Writes to either bit during sleep therefore leave the bypass paths unchanged. A reference-clock counter also checks the reset pin. It measures how long reset is held while the chip is awake, which covers the time after power-up and the time after leaving sleep. If reset is released before the minimum hold time, a violation flag is raised.

The sleep and reset pins are asynchronous. Each passes through its own two-flop synchronizer. The sleep path has one further stage, so that the captured settings are valid before any output switches.

Top module: `sleep_bypass_ctrl`

## Requirements
- R1: While awake (sleep input low and settled for 3 clocks), mclk_out, sdo_out and aux_out equal int_mclk, int_sdo and int_aux, and all three enables mclk_oe, sdo_oe and aux_oe are 1.
- R2: Three clocks after sleep_in is seen high, core_clk_en is 0. It stays 0 for as long as the chip is asleep.
- R3: Two clocks after rst_in is seen high, core_clk_en is 0 whatever the value of sleep_in. It returns to 1 only when both synchronized pins are low.
- R4: If xprt_bit was 1 at sleep entry, then while asleep mclk_oe and sdo_oe are 1, mclk_out equals ext_mclk and sdo_out equals ser_din.
- R5: If xprt_bit was 0 at sleep entry, then while asleep mclk_oe and sdo_oe are 0, and mclk_out and sdo_out are driven 0.
- R6: While asleep, aux_oe is 1 and aux_out equals ws_in only if both xprt_bit and wssel_bit were 1 at sleep entry. Otherwise aux_oe is 0 and aux_out is 0.
- R7: xprt_bit and wssel_bit are captured once, on the clock where synchronized sleep rises. Changing either bit during sleep has no effect on any output enable or output value.
- R8: When rst_in is released after being held high for fewer than HOLD_MIN_CYC awake clocks, hold_viol becomes 1 and stays 1 until rst_in is next asserted. A hold of HOLD_MIN_CYC clocks or more leaves hold_viol at 0.
- R9: hold_viol is 0 while the synchronized reset is high. Clocks during which the chip is asleep do not count toward the reset hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for synchronizers and the hold counter |
| sleep_in | input | 1 | Asynchronous sleep request, active high |
| rst_in | input | 1 | Asynchronous chip reset, active high |
| xprt_bit | input | 1 | Transparent-mode setting |
| wssel_bit | input | 1 | Setting that routes word select to the auxiliary pin during sleep |
| int_mclk | input | 1 | Internal master clock used while awake |
| int_sdo | input | 1 | Internal serial data used while awake |
| int_aux | input | 1 | Internal auxiliary output used while awake |
| ext_mclk | input | 1 | External master clock for bypass |
| ser_din | input | 1 | Serial data input for bypass |
| ws_in | input | 1 | Word select input for auxiliary bypass |
| core_clk_en | output | 1 | Enable for all internal clocks |
| mclk_out | output | 1 | Master clock output value |
| mclk_oe | output | 1 | Master clock output enable (0 = high impedance) |
| sdo_out | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Serial data output enable |
| aux_out | output | 1 | Auxiliary output value |
| aux_oe | output | 1 | Auxiliary output enable |
| hold_viol | output | 1 | Reset released too early |

## Verification
The assertions assume that rst_in is held high from time zero for longer than the synchronizer depth. They also assume that sleep_in is low at start, so the $past-based relations between sleep_in, core_clk_en and hold_viol see defined history. Every property is disabled while rst_in is high, so no reset edge inside the sleep window is ever judged.

The stimulus drives every input on the falling clock edge. After each change of sleep_in or rst_in, it waits at least as many clocks as the synchronizer depth before sampling. For each assertion's disable condition, it holds the related pins steady across that window.

// File: rtl/sleep_bypass_ctrl.sv
module sleep_bypass_ctrl #(
  parameter int HOLD_MIN_CYC = 50000
) (
  input  logic clk,
  input  logic sleep_in,
  input  logic rst_in,
  input  logic xprt_bit,
  input  logic wssel_bit,
  input  logic int_mclk,
  input  logic int_sdo,
  input  logic int_aux,
  input  logic ext_mclk,
  input  logic ser_din,
  input  logic ws_in,
  output logic core_clk_en,
  output logic mclk_out,
  output logic mclk_oe,
  output logic sdo_out,
  output logic sdo_oe,
  output logic aux_out,
  output logic aux_oe,
  output logic hold_viol
);
  localparam int CW = $clog2(HOLD_MIN_CYC + 1);
  localparam logic [CW-1:0] HOLD_MIN = CW'(HOLD_MIN_CYC);

  logic [2:0]    slp_q;
  logic [2:0]    rst_q;
  logic          xprt_lat;
  logic          wssel_lat;
  logic [CW-1:0] hold_cnt;
  logic          viol_q;

  logic asleep, rst_s, rst_rel, slp_entry;
  assign asleep    = slp_q[2];
  assign rst_s     = rst_q[1];
  assign rst_rel   = rst_q[2] & ~rst_q[1];
  assign slp_entry = slp_q[1] & ~slp_q[2];

  always_ff @(posedge clk) begin
    slp_q <= {slp_q[1:0], sleep_in};
    rst_q <= {rst_q[1:0], rst_in};
  end

  always_ff @(posedge clk) begin
    if (slp_entry) begin
      xprt_lat  <= xprt_bit;
      wssel_lat <= wssel_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_s || asleep)
      hold_cnt <= '0;
    else if (hold_cnt != HOLD_MIN)
      hold_cnt <= hold_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_s)
      viol_q <= 1'b0;
    else if (rst_rel && (hold_cnt < HOLD_MIN))
      viol_q <= 1'b1;
  end

  assign core_clk_en = ~asleep & ~rst_s;
  assign hold_viol   = viol_q;

  assign mclk_oe  = asleep ? xprt_lat : 1'b1;
  assign sdo_oe   = asleep ? xprt_lat : 1'b1;
  assign aux_oe   = asleep ? (xprt_lat & wssel_lat) : 1'b1;

  assign mclk_out = asleep ? (xprt_lat & ext_mclk) : int_mclk;
  assign sdo_out  = asleep ? (xprt_lat & ser_din) : int_sdo;
  assign aux_out  = asleep ? (xprt_lat & wssel_lat & ws_in) : int_aux;
endmodule

// File: rtl/sleep_bypass_ctrl_chk.sv
module sleep_bypass_ctrl_chk (
  input logic clk,
  input logic sleep_in,
  input logic rst_in,
  input logic ext_mclk,
  input logic core_clk_en,
  input logic mclk_out,
  input logic mclk_oe,
  input logic aux_oe,
  input logic hold_viol
);
  // R2
  clk_en_sleep_chk: assert property (@(posedge clk) disable iff (rst_in)
    ($past(sleep_in, 3) && $past(sleep_in, 4)) |-> !core_clk_en);

  // R4
  mclk_bypass_chk: assert property (@(posedge clk) disable iff (rst_in)
    ($past(sleep_in, 3) && $past(sleep_in, 4) && mclk_oe) |-> (mclk_out == ext_mclk));

  // R6
  aux_needs_xprt_chk: assert property (@(posedge clk) disable iff (rst_in)
    ($past(sleep_in, 3) && $past(sleep_in, 4) && aux_oe) |-> mclk_oe);

  // R7
  sel_frozen_chk: assert property (@(posedge clk) disable iff (rst_in)
    ($past(sleep_in, 3) && $past(sleep_in, 4)) |-> ($stable(mclk_oe) && $stable(aux_oe)));

  // R8
  viol_on_release_chk: assert property (@(posedge clk) disable iff (rst_in)
    $rose(hold_viol) |-> ($past(rst_in, 4) && !$past(rst_in, 3)));
endmodule

bind sleep_bypass_ctrl sleep_bypass_ctrl_chk chk_i (
  .clk(clk), .sleep_in(sleep_in), .rst_in(rst_in), .ext_mclk(ext_mclk),
  .core_clk_en(core_clk_en), .mclk_out(mclk_out), .mclk_oe(mclk_oe),
  .aux_oe(aux_oe), .hold_viol(hold_viol)
);

// File: tb/sleep_bypass_ctrl_test.sv
module sleep_bypass_ctrl_test;
  localparam int HOLD = 20;

  logic clk = 1'b0;
  logic sleep_in = 1'b0, rst_in = 1'b1, xprt_bit = 1'b0, wssel_bit = 1'b0;
  logic int_mclk = 1'b0, int_sdo = 1'b0, int_aux = 1'b0;
  logic ext_mclk = 1'b0, ser_din = 1'b0, ws_in = 1'b0;
  logic core_clk_en, mclk_out, mclk_oe, sdo_out, sdo_oe, aux_out, aux_oe, hold_viol;

  int n_chk = 0;
  int n_bad = 0;

  // {xprt, wssel, expected mclk/sdo enable, expected aux enable}
  localparam logic [3:0] VEC [4] = '{4'b0000, 4'b0100, 4'b1010, 4'b1111};

  always #10 clk = ~clk;

  sleep_bypass_ctrl #(.HOLD_MIN_CYC(HOLD)) uut (
    .clk(clk), .sleep_in(sleep_in), .rst_in(rst_in), .xprt_bit(xprt_bit),
    .wssel_bit(wssel_bit), .int_mclk(int_mclk), .int_sdo(int_sdo), .int_aux(int_aux),
    .ext_mclk(ext_mclk), .ser_din(ser_din), .ws_in(ws_in), .core_clk_en(core_clk_en),
    .mclk_out(mclk_out), .mclk_oe(mclk_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
    .aux_out(aux_out), .aux_oe(aux_oe), .hold_viol(hold_viol)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic check_awake(input logic m, input logic s, input logic a);
    int_mclk = m; int_sdo = s; int_aux = a;
    #1;
    chk("R1 mclk_out", mclk_out, m);
    chk("R1 sdo_out", sdo_out, s);
    chk("R1 aux_out", aux_out, a);
    chk("R1 mclk_oe", mclk_oe, 1'b1);
    chk("R1 sdo_oe", sdo_oe, 1'b1);
    chk("R1 aux_oe", aux_oe, 1'b1);
  endtask

  task automatic check_asleep(input logic moe, input logic aoe, input logic d);
    ext_mclk = d; ser_din = ~d; ws_in = d;
    #1;
    chk("R4/R5 mclk_oe", mclk_oe, moe);
    chk("R4/R5 sdo_oe", sdo_oe, moe);
    chk("R4/R5 mclk_out", mclk_out, moe & d);
    chk("R4/R5 sdo_out", sdo_out, moe & ~d);
    chk("R6 aux_oe", aux_oe, aoe);
    chk("R6 aux_out", aux_out, aoe & d);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_cyc(30);
    chk("R3 clk_en in reset", core_clk_en, 1'b0);
    chk("R9 viol in reset", hold_viol, 1'b0);
    rst_in = 1'b0;
    wait_cyc(6);
    chk("R3 clk_en after reset", core_clk_en, 1'b1);
    chk("R8 long hold no viol", hold_viol, 1'b0);
    check_awake(1'b1, 1'b0, 1'b1);
    check_awake(1'b0, 1'b1, 1'b0);

    for (int i = 0; i < 4; i++) begin
      xprt_bit = VEC[i][3]; wssel_bit = VEC[i][2];
      sleep_in = 1'b1;
      wait_cyc(5);
      chk("R2 clk_en asleep", core_clk_en, 1'b0);
      check_asleep(VEC[i][1], VEC[i][0], 1'b1);
      wait_cyc(1);
      check_asleep(VEC[i][1], VEC[i][0], 1'b0);
      xprt_bit = ~VEC[i][3]; wssel_bit = ~VEC[i][2];
      wait_cyc(4);
      // R7: settings written during sleep must not matter
      check_asleep(VEC[i][1], VEC[i][0], 1'b1);
      sleep_in = 1'b0;
      wait_cyc(5);
      chk("R2 clk_en after wake", core_clk_en, 1'b1);
      check_awake(1'b1, 1'b1, 1'b0);
    end

    rst_in = 1'b1;
    wait_cyc(HOLD - 1);
    rst_in = 1'b0;
    wait_cyc(6);
    chk("R8 short hold viol", hold_viol, 1'b1);
    wait_cyc(3);
    chk("R8 viol sticky", hold_viol, 1'b1);

    rst_in = 1'b1;
    wait_cyc(4);
    chk("R9 viol cleared", hold_viol, 1'b0);
    sleep_in = 1'b0;
    chk("R3 clk_en reset awake", core_clk_en, 1'b0);
    wait_cyc(HOLD - 4);
    rst_in = 1'b0;
    wait_cyc(6);
    chk("R8 exact hold no viol", hold_viol, 1'b0);

    sleep_in = 1'b1;
    wait_cyc(5);
    rst_in = 1'b1;
    wait_cyc(30);
    chk("R3 clk_en reset asleep", core_clk_en, 1'b0);
    sleep_in = 1'b0;
    wait_cyc(10);
    chk("R3 clk_en reset woke", core_clk_en, 1'b0);
    rst_in = 1'b0;
    wait_cyc(6);
    chk("R9 sleep not counted", hold_viol, 1'b1);

    rst_in = 1'b1;
    wait_cyc(HOLD + 5);
    rst_in = 1'b0;
    wait_cyc(6);
    chk("R8 clean after long hold", hold_viol, 1'b0);
    finish_run();
  end
endmodule